// File: doc/BRIEF.md
# Byte-Serial 32-bit x86 Instruction Decoder

This block accepts a stream of x86 instruction bytes, one byte for each valid/ready handshake, and decodes a small subset of 32-bit instructions. For each instruction it produces one output record. The record holds:

- the prefix flags;
- the effective operand size;
- the primary opcode;
- the ModR/M fields and, when present, the SIB fields;
- the displacement and the immediate;
- the total length in bytes.

Three opcode forms are supported:

- move-immediate with the register number in the opcode (B8h–BFh);
- the opcode-extension form F7h, where the ModR/M reg field is an extension digit;
- register/memory forms 01h, 89h and 8Bh, plus 6Bh, which adds a sign-extended 8-bit immediate.

The decoder branches on the ModR/M and SIB bytes to decide how many addressing bytes follow. It assembles multi-byte fields little-endian. Any other opcode yields an error record. So does an instruction that would run past the length limit. After an error record the decoder treats the next byte as the start of a new instruction.

A completed record stays on the output with valid high until the consumer accepts it. While a record is pending, the decoder accepts no input bytes.

Top module: `x86_byte_decoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Prefix handling. Prefix bytes are consumed before the opcode, may repeat, and each counts toward the length.
  - F0h sets out_lock.
  - F2h sets out_rep to 1 and F3h sets it to 2.
  - Segment overrides map to out_seg as follows: 26h=1, 2Eh=2, 36h=3, 3Eh=4, 64h=5, 65h=6.
  - For out_rep and out_seg, the last prefix seen wins.
  - 66h sets out_op16 and 67h sets out_adsz.
- R3: Opcodes B8h–BFh carry the destination register in opcode bits 2:0, which appear on out_reg, and have no ModR/M byte. They take a 4-byte little-endian immediate, or a 2-byte immediate zero-extended when out_op16 is set.
- R4: A ModR/M byte is split as mod in bits 7:6, reg in bits 5:3 and r/m in bits 2:0. For F7h the reg field is an extension digit: digits 2–7 decode normally, and digits 0 and 1 give an error record. For example, F7h F1h decodes as mod=3, reg=6, r/m=1, length 2.
- R5: Opcodes 01h, 89h and 8Bh take a ModR/M byte and no immediate. Opcode 6Bh takes a ModR/M byte and then one immediate byte, sign-extended to 32 bits. For example, 6Bh C9h 0Ch gives reg=1, r/m=1, imm=12.
- R6: When mod is 3, no SIB byte and no displacement follow.
- R7: A SIB byte follows exactly when mod is not 3 and r/m is 4. It is split as scale in bits 7:6, index in bits 5:3 and base in bits 2:0. With mod 0, a SIB base of 5 adds a 4-byte displacement.
- R8: The displacement length depends on mod and r/m:
  - mod 1 gives 1 byte, sign-extended;
  - mod 2 gives 4 bytes;
  - mod 0 with r/m 5 gives 4 bytes;
  - mod 0 otherwise gives none.
  A 4-byte displacement is assembled little-endian.
- R9: out_len equals the number of bytes in the instruction. Fields that do not apply to the instruction read 0.
- R10: An opcode outside the supported set gives a record with out_err=1 and out_len equal to the bytes consumed. The next byte starts a new instruction.
- R11: If byte MAX_LEN is consumed and the instruction is still incomplete, the record shows out_err=1 and out_len=MAX_LEN, and the decoder resynchronises.
- R12: The record and out_valid hold until out_ready is seen. in_ready stays 0 while a record is pending, and a byte offered meanwhile is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Record pending |
| out_ready | input | 1 | Consumer accepts record |
| out_err | output | 1 | Unsupported opcode or length overrun |
| out_lock | output | 1 | Lock prefix seen |
| out_rep | output | 2 | Repeat prefix code |
| out_seg | output | 3 | Segment override code |
| out_op16 | output | 1 | Operand size is 16 bits |
| out_adsz | output | 1 | Address-size prefix seen |
| out_opcode | output | 8 | Primary opcode |
| out_has_modrm | output | 1 | ModR/M byte present |
| out_mod | output | 2 | ModR/M mod |
| out_reg | output | 3 | ModR/M reg, or register from opcode |
| out_rm | output | 3 | ModR/M r/m |
| out_has_sib | output | 1 | SIB byte present |
| out_scale | output | 2 | SIB scale |
| out_index | output | 3 | SIB index |
| out_base | output | 3 | SIB base |
| out_disp | output | 32 | Displacement |
| out_imm | output | 32 | Immediate |
| out_len | output | $clog2(MAX_LEN+1) | Instruction length in bytes |

## Verification
The bench builds the decoder with the default MAX_LEN of 15. At that value a run of ten lock prefixes plus a five-byte move lands exactly on the limit. Fourteen prefixes plus a move opcode overruns it, so both sides of the length check are exercised. Random instructions of up to eleven bytes mix prefixes, every ModR/M mode and SIB bases. This covers every displacement length, well inside the limit.

// File: rtl/x86d_pkg.sv
// Shared types for the byte-serial x86 decoder.
// Assumes 32-bit default operand and address size.
package x86d_pkg;
    typedef enum logic [2:0] {
        ST_PFX, ST_MODRM, ST_SIB, ST_DISP, ST_IMM, ST_DONE
    } dec_state_e;

    typedef enum logic [2:0] {
        OPK_BAD, OPK_MOVI, OPK_EXT, OPK_RM, OPK_RM_I8
    } op_kind_e;

    localparam logic [1:0] REP_NONE = 2'd0;
    localparam logic [1:0] REP_NE   = 2'd1;
    localparam logic [1:0] REP_E    = 2'd2;
endpackage

// File: rtl/x86d_prefix_class.sv
// Classifies one byte as a prefix and reports its effect.
// Purely combinational; assumes the caller only uses it before the opcode.
module x86d_prefix_class (
    input  logic [7:0] byte_in,
    output logic       is_pfx,
    output logic       is_lock,
    output logic [1:0] rep_code,
    output logic [2:0] seg_code,
    output logic       is_opsz,
    output logic       is_adsz
);
    import x86d_pkg::*;

    // Decode the prefix byte into flags and codes.
    always_comb begin
        is_lock  = 1'b0;
        rep_code = REP_NONE;
        seg_code = 3'd0;
        is_opsz  = 1'b0;
        is_adsz  = 1'b0;
        case (byte_in)
            8'hF0: is_lock  = 1'b1;
            8'hF2: rep_code = REP_NE;
            8'hF3: rep_code = REP_E;
            8'h26: seg_code = 3'd1;
            8'h2E: seg_code = 3'd2;
            8'h36: seg_code = 3'd3;
            8'h3E: seg_code = 3'd4;
            8'h64: seg_code = 3'd5;
            8'h65: seg_code = 3'd6;
            8'h66: is_opsz  = 1'b1;
            8'h67: is_adsz  = 1'b1;
            default: ;
        endcase
        is_pfx = is_lock | (rep_code != REP_NONE) | (seg_code != 3'd0)
               | is_opsz | is_adsz;
    end
endmodule

// File: rtl/x86d_opcode_class.sv
// Maps a primary opcode byte to its decoding form.
// Combinational; unsupported opcodes map to OPK_BAD.
module x86d_opcode_class (
    input  logic [7:0]         op_in,
    output x86d_pkg::op_kind_e kind
);
    import x86d_pkg::*;

    // Select the opcode form.
    always_comb begin
        if (op_in[7:3] == 5'b10111) begin
            kind = OPK_MOVI;
        end else begin
            case (op_in)
                8'hF7:                kind = OPK_EXT;
                8'h01, 8'h89, 8'h8B:  kind = OPK_RM;
                8'h6B:                kind = OPK_RM_I8;
                default:              kind = OPK_BAD;
            endcase
        end
    end
endmodule

// File: rtl/x86d_addr_len.sv
// From a ModR/M byte, decides whether a SIB byte follows and how many
// displacement bytes the ModR/M alone implies. 32-bit addressing only.
module x86d_addr_len (
    input  logic [1:0] mod_in,
    input  logic [2:0] rm_in,
    output logic       need_sib,
    output logic [2:0] disp_len
);
    // Work out SIB presence and displacement size.
    always_comb begin
        need_sib = (mod_in != 2'b11) && (rm_in == 3'b100);
        case (mod_in)
            2'b00:   disp_len = (rm_in == 3'b101) ? 3'd4 : 3'd0;
            2'b01:   disp_len = 3'd1;
            2'b10:   disp_len = 3'd4;
            default: disp_len = 3'd0;
        endcase
    end
endmodule

// File: rtl/x86_byte_decoder.sv
// Byte-serial decoder for a subset of 32-bit x86 instructions.
// Consumes one byte per in_valid/in_ready handshake and holds one output
// record until out_ready. Assumes 32-bit defaults; 67h is only recorded.
module x86_byte_decoder #(
    parameter int MAX_LEN = 15,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_err,
    output logic             out_lock,
    output logic [1:0]       out_rep,
    output logic [2:0]       out_seg,
    output logic             out_op16,
    output logic             out_adsz,
    output logic [7:0]       out_opcode,
    output logic             out_has_modrm,
    output logic [1:0]       out_mod,
    output logic [2:0]       out_reg,
    output logic [2:0]       out_rm,
    output logic             out_has_sib,
    output logic [1:0]       out_scale,
    output logic [2:0]       out_index,
    output logic [2:0]       out_base,
    output logic [31:0]      out_disp,
    output logic [31:0]      out_imm,
    output logic [LEN_W-1:0] out_len
);
    import x86d_pkg::*;

    dec_state_e       state_q, nxt;
    op_kind_e         kind_q, kind_c;
    logic [LEN_W-1:0] cnt_q;
    logic [2:0]       disp_left_q, disp_n;
    logic [2:0]       imm_left_q, imm_n;
    logic [1:0]       pos_q;
    logic             bad;
    logic             fire;

    logic             err_q, lock_q, op16_q, adsz_q, hmod_q, hsib_q;
    logic [1:0]       rep_q, mod_q, scale_q;
    logic [2:0]       seg_q, reg_q, rm_q, index_q, base_q;
    logic [7:0]       opc_q;
    logic [31:0]      disp_q, imm_q;

    logic             p_is, p_lock, p_opsz, p_adsz;
    logic [1:0]       p_rep;
    logic [2:0]       p_seg;
    logic             m_sib;
    logic [2:0]       m_disp;

    x86d_prefix_class u_pfx (
        .byte_in (in_data), .is_pfx (p_is), .is_lock (p_lock),
        .rep_code(p_rep), .seg_code(p_seg), .is_opsz (p_opsz), .is_adsz(p_adsz)
    );

    x86d_opcode_class u_opc (.op_in(in_data), .kind(kind_c));

    x86d_addr_len u_alen (
        .mod_in(in_data[7:6]), .rm_in(in_data[2:0]),
        .need_sib(m_sib), .disp_len(m_disp)
    );

    assign in_ready = (state_q != ST_DONE);
    assign fire     = in_valid && in_ready;

    // Next decode step for the byte on in_data, plus error detection.
    always_comb begin
        nxt    = state_q;
        bad    = 1'b0;
        disp_n = disp_left_q;
        imm_n  = imm_left_q;
        case (state_q)
            ST_PFX: begin
                if (!p_is) begin
                    case (kind_c)
                        OPK_MOVI:  begin imm_n = op16_q ? 3'd2 : 3'd4; nxt = ST_IMM; end
                        OPK_EXT,
                        OPK_RM:    begin imm_n = 3'd0; nxt = ST_MODRM; end
                        OPK_RM_I8: begin imm_n = 3'd1; nxt = ST_MODRM; end
                        default:   bad = 1'b1;
                    endcase
                end
            end
            ST_MODRM: begin
                disp_n = m_disp;
                if (kind_q == OPK_EXT && in_data[5:4] == 2'b00) bad = 1'b1;
                if (m_sib)                  nxt = ST_SIB;
                else if (m_disp != 3'd0)    nxt = ST_DISP;
                else if (imm_n != 3'd0)     nxt = ST_IMM;
                else                        nxt = ST_DONE;
            end
            ST_SIB: begin
                if (mod_q == 2'b00 && in_data[2:0] == 3'b101) disp_n = 3'd4;
                if (disp_n != 3'd0)         nxt = ST_DISP;
                else if (imm_n != 3'd0)     nxt = ST_IMM;
                else                        nxt = ST_DONE;
            end
            ST_DISP: begin
                disp_n = disp_left_q - 3'd1;
                if (disp_n != 3'd0)         nxt = ST_DISP;
                else if (imm_n != 3'd0)     nxt = ST_IMM;
                else                        nxt = ST_DONE;
            end
            ST_IMM: begin
                imm_n = imm_left_q - 3'd1;
                nxt   = (imm_n != 3'd0) ? ST_IMM : ST_DONE;
            end
            default: ;
        endcase
        if (!bad && nxt != ST_DONE && cnt_q == LEN_W'(MAX_LEN - 1)) bad = 1'b1;
    end

    // Control state, counters and record fields.
    always_ff @(posedge clk) begin
        if (!rst_n || (state_q == ST_DONE && out_ready)) begin
            state_q <= ST_PFX;  kind_q <= OPK_BAD;  cnt_q <= '0;
            disp_left_q <= '0;  imm_left_q <= '0;   pos_q <= '0;
            err_q <= 1'b0;  lock_q <= 1'b0;  op16_q <= 1'b0;  adsz_q <= 1'b0;
            hmod_q <= 1'b0; hsib_q <= 1'b0;  rep_q <= '0;     seg_q <= '0;
            mod_q <= '0;    scale_q <= '0;   reg_q <= '0;     rm_q <= '0;
            index_q <= '0;  base_q <= '0;    opc_q <= '0;
            disp_q <= '0;   imm_q <= '0;
        end else if (fire) begin
            cnt_q       <= cnt_q + 1'b1;
            disp_left_q <= disp_n;
            imm_left_q  <= imm_n;
            state_q     <= bad ? ST_DONE : nxt;
            err_q       <= bad;
            case (state_q)
                ST_PFX: begin
                    if (p_is) begin
                        if (p_lock) lock_q <= 1'b1;
                        if (p_rep != REP_NONE) rep_q <= p_rep;
                        if (p_seg != 3'd0) seg_q <= p_seg;
                        if (p_opsz) op16_q <= 1'b1;
                        if (p_adsz) adsz_q <= 1'b1;
                    end else begin
                        opc_q  <= in_data;
                        kind_q <= kind_c;
                        if (kind_c == OPK_MOVI) reg_q <= in_data[2:0];
                    end
                end
                ST_MODRM: begin
                    hmod_q <= 1'b1;
                    mod_q  <= in_data[7:6];
                    reg_q  <= in_data[5:3];
                    rm_q   <= in_data[2:0];
                end
                ST_SIB: begin
                    hsib_q  <= 1'b1;
                    scale_q <= in_data[7:6];
                    index_q <= in_data[5:3];
                    base_q  <= in_data[2:0];
                end
                ST_DISP: begin
                    disp_q[{pos_q, 3'b000} +: 8] <= in_data;
                    pos_q <= (disp_n == 3'd0) ? 2'd0 : pos_q + 2'd1;
                    if (disp_n == 3'd0 && mod_q == 2'b01)
                        disp_q[31:8] <= {24{in_data[7]}};
                end
                ST_IMM: begin
                    imm_q[{pos_q, 3'b000} +: 8] <= in_data;
                    pos_q <= pos_q + 2'd1;
                    if (kind_q == OPK_RM_I8)
                        imm_q[31:8] <= {24{in_data[7]}};
                end
                default: ;
            endcase
        end
    end

    assign out_valid     = (state_q == ST_DONE);
    assign out_err       = err_q;
    assign out_lock      = lock_q;
    assign out_rep       = rep_q;
    assign out_seg       = seg_q;
    assign out_op16      = op16_q;
    assign out_adsz      = adsz_q;
    assign out_opcode    = opc_q;
    assign out_has_modrm = hmod_q;
    assign out_mod       = mod_q;
    assign out_reg       = reg_q;
    assign out_rm        = rm_q;
    assign out_has_sib   = hsib_q;
    assign out_scale     = scale_q;
    assign out_index     = index_q;
    assign out_base      = base_q;
    assign out_disp      = disp_q;
    assign out_imm       = imm_q;
    assign out_len       = cnt_q;

    // R12: no byte is taken while a record waits.
    a_r12_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R12: an unaccepted record stays put.
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_len)
            && $stable(out_opcode) && $stable(out_imm) && $stable(out_disp)));

    // R9: a finished record has a length inside the limit.
    a_r9_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len != '0 && out_len <= LEN_W'(MAX_LEN)));

    // R6: register-direct ModR/M carries no SIB and no displacement.
    a_r6_reg_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && out_has_modrm && out_mod == 2'b11)
            |-> (!out_has_sib && out_disp == 32'd0));

    // R7: a SIB byte only follows a memory ModR/M with r/m 100b.
    a_r7_sib_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_has_sib)
            |-> (out_has_modrm && out_mod != 2'b11 && out_rm == 3'b100));

    // R3: move-immediate names its register from the opcode, no ModR/M.
    a_r3_movi_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && out_opcode[7:3] == 5'b10111)
            |-> (!out_has_modrm && out_reg == out_opcode[2:0]));
endmodule

// File: tb/tb_x86_byte_decoder.sv
module tb_x86_byte_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_LEN    = 15;
    localparam int LEN_W      = $clog2(MAX_LEN + 1);

    typedef struct packed {
        logic err; logic lock; logic [1:0] rep; logic [2:0] seg;
        logic op16; logic adsz; logic [7:0] opcode; logic has_modrm;
        logic [1:0] mod; logic [2:0] regf; logic [2:0] rm; logic has_sib;
        logic [1:0] scale; logic [2:0] index; logic [2:0] base;
        logic [31:0] disp; logic [31:0] imm; logic [LEN_W-1:0] len;
    } rec_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, out_valid, out_err, out_lock, out_op16, out_adsz;
    logic out_has_modrm, out_has_sib;
    logic [1:0] out_rep, out_mod, out_scale;
    logic [2:0] out_seg, out_reg, out_rm, out_index, out_base;
    logic [7:0] out_opcode;
    logic [31:0] out_disp, out_imm;
    logic [LEN_W-1:0] out_len;

    int checks = 0, fails = 0, cycles = 0;
    rec_t e;
    logic [7:0] bytes [0:31];
    int nb;

    x86_byte_decoder #(.MAX_LEN(MAX_LEN)) dut (
        .clk, .rst_n, .in_valid, .in_data, .in_ready, .out_valid, .out_ready,
        .out_err, .out_lock, .out_rep, .out_seg, .out_op16, .out_adsz,
        .out_opcode, .out_has_modrm, .out_mod, .out_reg, .out_rm,
        .out_has_sib, .out_scale, .out_index, .out_base, .out_disp,
        .out_imm, .out_len
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks = checks + 1; fails = fails + 1;
            $display("FAIL watchdog: got hung run exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic rec_t actual();
        rec_t a;
        a = '{out_err, out_lock, out_rep, out_seg, out_op16, out_adsz,
              out_opcode, out_has_modrm, out_mod, out_reg, out_rm,
              out_has_sib, out_scale, out_index, out_base, out_disp,
              out_imm, out_len};
        return a;
    endfunction

    task automatic check(input string tag, input logic ok,
                         input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        bytes[nb] = b; nb++;
    endtask

    task automatic add_prefix(input logic [7:0] p);
        push(p);
        case (p)
            8'hF0: e.lock = 1'b1;
            8'hF2: e.rep = 2'd1;
            8'hF3: e.rep = 2'd2;
            8'h26: e.seg = 3'd1;
            8'h2E: e.seg = 3'd2;
            8'h36: e.seg = 3'd3;
            8'h3E: e.seg = 3'd4;
            8'h64: e.seg = 3'd5;
            8'h65: e.seg = 3'd6;
            8'h66: e.op16 = 1'b1;
            8'h67: e.adsz = 1'b1;
            default: ;
        endcase
    endtask

    // Encoder for the ModR/M, optional SIB and displacement (R6, R7, R8).
    task automatic add_modrm(input logic [7:0] m);
        int dl;
        logic [7:0] s, b;
        push(m);
        e.has_modrm = 1'b1; e.mod = m[7:6]; e.regf = m[5:3]; e.rm = m[2:0];
        dl = (m[7:6] == 2'd1) ? 1 : (m[7:6] == 2'd2) ? 4 :
             (m[7:6] == 2'd0 && m[2:0] == 3'd5) ? 4 : 0;
        if (m[7:6] != 2'd3 && m[2:0] == 3'd4) begin
            s = 8'($urandom);
            push(s);
            e.has_sib = 1'b1; e.scale = s[7:6]; e.index = s[5:3]; e.base = s[2:0];
            if (m[7:6] == 2'd0 && s[2:0] == 3'd5) dl = 4;
        end
        for (int i = 0; i < dl; i++) begin
            b = 8'($urandom);
            push(b);
            e.disp[8*i +: 8] = b;
        end
        if (dl == 1) e.disp[31:8] = {24{e.disp[7]}};
    endtask

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1; in_data = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic accept();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    // Send the encoded bytes, compare the record, accept it.
    task automatic run(input string tag);
        rec_t a;
        e.len = LEN_W'(nb);
        for (int i = 0; i < nb; i++) send_byte(bytes[i]);
        a = actual();
        check({tag, " valid"}, out_valid === 1'b1, 128'(out_valid), 128'(1));
        if (e.err)
            check(tag, a.err === 1'b1 && a.len === e.len,
                  128'({a.err, a.len}), 128'({e.err, e.len}));
        else
            check(tag, a === e, 128'(a), 128'(e));
        accept();
    endtask

    task automatic start();
        e = '0; nb = 0;
    endtask

    task automatic gen_random();
        int np, form;
        logic [7:0] pl [0:10];
        logic [7:0] b;
        pl = '{8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64,
               8'h65, 8'h66, 8'h67};
        start();
        np = $urandom_range(0, 3);
        for (int i = 0; i < np; i++) add_prefix(pl[$urandom_range(0, 10)]);
        form = $urandom_range(0, 3);
        case (form)
            0: begin
                b = 8'hB8 | 8'($urandom_range(0, 7));
                push(b); e.opcode = b; e.regf = b[2:0];
                for (int i = 0; i < (e.op16 ? 2 : 4); i++) begin
                    b = 8'($urandom); push(b); e.imm[8*i +: 8] = b;
                end
            end
            1: begin
                push(8'hF7); e.opcode = 8'hF7;
                b = 8'($urandom);
                b[5:3] = 3'($urandom_range(2, 7));
                add_modrm(b);
            end
            2: begin
                case ($urandom_range(0, 2))
                    0: b = 8'h01; 1: b = 8'h89; default: b = 8'h8B;
                endcase
                push(b); e.opcode = b;
                add_modrm(8'($urandom));
            end
            default: begin
                push(8'h6B); e.opcode = 8'h6B;
                add_modrm(8'($urandom));
                b = 8'($urandom); push(b);
                e.imm = {{24{b[7]}}, b};
            end
        endcase
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", out_valid === 1'b0 && in_ready === 1'b1,
              128'({out_valid, in_ready}), 128'({1'b0, 1'b1}));

        // R4: F7 F1 is divide by ecx.
        start(); push(8'hF7); e.opcode = 8'hF7; add_modrm(8'hF1);
        run("R4 div ecx");
        // R5: 6B C9 0C, imul with imm8.
        start(); push(8'h6B); e.opcode = 8'h6B; add_modrm(8'hC9);
        push(8'h0C); e.imm = 32'd12; run("R5 imul imm8");
        // R5: negative imm8 sign-extends.
        start(); push(8'h6B); e.opcode = 8'h6B; add_modrm(8'hD8);
        push(8'hF6); e.imm = 32'hFFFF_FFF6; run("R5 imm8 sign");
        // R3: 32-bit move immediate into ecx.
        start(); push(8'hB9); e.opcode = 8'hB9; e.regf = 3'd1;
        push(8'h78); push(8'h56); push(8'h34); push(8'h12);
        e.imm = 32'h1234_5678; run("R3 mov imm32");
        // R3 R2: 66h gives a 16-bit immediate; repeated 66h accepted.
        start(); add_prefix(8'h66); add_prefix(8'h66); push(8'hBF);
        e.opcode = 8'hBF; e.regf = 3'd7;
        push(8'hCD); push(8'hAB); e.imm = 32'h0000_ABCD; run("R3 mov imm16");
        // R2: last repeat and segment prefix win; lock and 67h recorded.
        start(); add_prefix(8'hF2); add_prefix(8'h2E); add_prefix(8'hF3);
        add_prefix(8'h65); add_prefix(8'hF0); add_prefix(8'h67);
        push(8'h89); e.opcode = 8'h89; add_modrm(8'hC8); run("R2 prefixes");
        // R7 R8: SIB with base 5 and mod 0 adds disp32.
        start(); push(8'h8B); e.opcode = 8'h8B;
        push(8'h04); e.has_modrm = 1'b1; e.rm = 3'd4;
        push(8'h8D); e.has_sib = 1'b1; e.scale = 2'd2; e.index = 3'd1; e.base = 3'd5;
        push(8'h44); push(8'h33); push(8'h22); push(8'h11);
        e.disp = 32'h1122_3344; run("R7 sib disp32");
        // R8: mod 1 disp8 sign-extended.
        start(); push(8'h8B); e.opcode = 8'h8B;
        push(8'h45); e.has_modrm = 1'b1; e.mod = 2'd1; e.rm = 3'd5;
        push(8'hF0); e.disp = 32'hFFFF_FFF0; run("R8 disp8");
        // R8: mod 0 r/m 5 disp32 without base.
        start(); push(8'h01); e.opcode = 8'h01;
        push(8'h1D); e.has_modrm = 1'b1; e.regf = 3'd3; e.rm = 3'd5;
        push(8'hEF); push(8'hBE); push(8'hAD); push(8'hDE);
        e.disp = 32'hDEAD_BEEF; run("R8 disp32 abs");
        // R6: mod 3 ends after ModR/M.
        start(); push(8'h01); e.opcode = 8'h01; add_modrm(8'hE4); run("R6 reg direct");
        // R10: unknown opcode, then resync on a good one.
        start(); push(8'h90); e.err = 1'b1; run("R10 bad opcode");
        start(); push(8'hF7); e.opcode = 8'hF7; add_modrm(8'hF3); run("R10 resync");
        // R4: F7 extension 0 is rejected after the ModR/M.
        start(); push(8'hF7); push(8'hC1); e.err = 1'b1; run("R4 ext0 err");
        // R11: exactly MAX_LEN bytes is legal.
        start(); for (int i = 0; i < 10; i++) add_prefix(8'hF0);
        push(8'hB8); e.opcode = 8'hB8;
        push(8'h01); push(8'h02); push(8'h03); push(8'h04);
        e.imm = 32'h0403_0201; run("R11 at limit");
        // R11: overrun at byte MAX_LEN.
        start(); for (int i = 0; i < 14; i++) add_prefix(8'hF0);
        push(8'hB8); e.err = 1'b1; run("R11 overrun");

        // R12: pending record holds, offered byte is not taken.
        start(); push(8'h89); e.opcode = 8'h89; add_modrm(8'hD9);
        e.len = LEN_W'(nb);
        for (int i = 0; i < nb; i++) send_byte(bytes[i]);
        in_valid = 1'b1; in_data = 8'hB8;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R12 hold", out_valid === 1'b1 && in_ready === 1'b0
                  && actual() === e, 128'(actual()), 128'(e));
        end
        in_valid = 1'b0;
        accept();
        start(); push(8'hF7); e.opcode = 8'hF7; add_modrm(8'hF9); run("R12 no take");

        // R9: random instruction mix.
        for (int n = 0; n < 400; n++) begin
            gen_random();
            run("R9 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule